// File: doc/BRIEF.md
# Byte Permute Unit with Per-Byte Bit Reversal

This unit rearranges the four bytes of a 32-bit word under control of a 9-bit immediate. Each destination byte has its own 2-bit selector that names the source byte it takes. A byte may be chosen for several destinations or for none. One more control bit mirrors the bit order inside every result byte after the bytes have been routed. The byte positions do not change when this happens.

The unit sits in an execute stage. Each issued operation carries its secondary opcode and the core's architecture feature level. The operation runs only when the secondary opcode names the permute and the core is at the newest feature level. In every other case the unit raises an illegal-opcode flag instead of a result. In the default registered variant the result, the valid and the flag all appear one clock after the issue strobe.

Top module: `byte_permute_unit`

## Requirements
- R1: Control bits 1:0 hold a value k in 0..3, and result bits 7:0 take source bits 8k+7..8k.
- R2: Control bit pairs 3:2, 5:4 and 7:6 choose the source byte for result bytes 1, 2 and 3 in the same way as R1.
- R3: Two or more selectors may hold the same value, and each of those result bytes then carries a copy of that one source byte.
- R4: When control bit 8 is 1, each result byte has its bit order mirrored: bit 0 trades places with bit 7, bit 1 with bit 6, and so on. No byte moves to a different position.
- R5: An operation is accepted only when the secondary opcode is 7'h07 and the feature level input is 2'd3. Any other issued operation gives out_illegal high, out_valid low and out_word zero.
- R6: In the registered variant, out_valid or out_illegal shows the outcome of an issue exactly one clock after that issue.
- R7: In a cycle with in_valid low, out_valid and out_illegal are low and out_word is zero on the next cycle.
- R8: While rst is high, out_valid, out_illegal and out_word all reset to zero.
- R9: Control 9'h0E4 returns the source unchanged, and control 9'h1E4 returns each source byte bit-mirrored in its own place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Issue strobe |
| src_word | input | 32 | Source word |
| ctrl_imm | input | 9 | Bit 8 enables mirroring; bits 7:0 hold four byte selectors, lane 0 lowest |
| sec_opcode | input | 7 | Secondary opcode of the issued operation |
| feat_level | input | 2 | Core feature level: 0 oldest through 3 newest |
| out_valid | output | 1 | Result valid |
| out_word | output | 32 | Permuted word, zero when not valid |
| out_illegal | output | 1 | Illegal-opcode indication |

## Verification
The assertions assume in_valid is low for the whole reset period. They also assume the sources only change away from the clock edge, so that a $past sample gives the value that was issued. The bench drives every input on the falling edge and keeps in_valid low during reset. It then mixes directed selector patterns with random words and controls. Some issues carry the right opcode but a lower feature level, and some carry a wrong opcode, so that only the accept condition decides between a result and the illegal flag.

// File: rtl/shuffle_pkg.sv
package shuffle_pkg;
    localparam int LANES     = 4;
    localparam int LANE_W    = 8;
    localparam int WORD_W    = LANES * LANE_W;
    localparam int SEL_W     = $clog2(LANES);
    localparam int CTRL_W    = LANES * SEL_W + 1;
    localparam int OPC_W     = 7;
    localparam logic [OPC_W-1:0] OPC_PERMUTE = 7'h07;

    typedef enum logic [1:0] {
        LVL_BASE   = 2'd0,
        LVL_MID    = 2'd1,
        LVL_HIGH   = 2'd2,
        LVL_NEWEST = 2'd3
    } feat_level_e;

    typedef logic [LANE_W-1:0] lane_t;

    typedef struct packed {
        logic                        mirror;
        logic [LANES-1:0][SEL_W-1:0] sel;
    } perm_ctrl_s;

    typedef struct packed {
        logic                    valid;
        logic                    illegal;
        logic [LANES-1:0][LANE_W-1:0] data;
    } perm_result_s;
endpackage

// File: rtl/shuf_lane_mux.sv
module shuf_lane_mux #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [LANES*LANE_W-1:0] src_flat,
    input  logic [SEL_W-1:0]        sel,
    output logic [LANE_W-1:0]       lane_out
);
    logic [LANE_W-1:0] lanes [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_split
        assign lanes[i] = src_flat[i*LANE_W +: LANE_W];
    end

    assign lane_out = lanes[sel];
endmodule

// File: rtl/shuf_bit_flip.sv
module shuf_bit_flip #(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] din,
    input  logic              en,
    output logic [LANE_W-1:0] dout
);
    logic [LANE_W-1:0] flipped;

    for (genvar b = 0; b < LANE_W; b++) begin : g_mirror
        assign flipped[b] = din[LANE_W-1-b];
    end

    assign dout = en ? flipped : din;
endmodule

// File: rtl/shuf_legal_check.sv
module shuf_legal_check
    import shuffle_pkg::*;
#(
    parameter int OPC_W_P = OPC_W
) (
    input  logic [OPC_W_P-1:0] opcode,
    input  feat_level_e        level,
    output logic               legal
);
    assign legal = (opcode == OPC_W_P'(OPC_PERMUTE)) && (level == LVL_NEWEST);
endmodule

// File: rtl/byte_permute_unit.sv
module byte_permute_unit
    import shuffle_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] src_word,
    input  logic [CTRL_W-1:0] ctrl_imm,
    input  logic [OPC_W-1:0]  sec_opcode,
    input  logic [1:0]        feat_level,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word,
    output logic              out_illegal
);
    perm_ctrl_s   ctrl;
    perm_result_s next_res;
    perm_result_s cur_res;
    logic [LANES-1:0][LANE_W-1:0] picked;
    logic [LANES-1:0][LANE_W-1:0] shaped;
    logic legal;

    assign ctrl = perm_ctrl_s'(ctrl_imm);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        shuf_lane_mux #(.LANES(LANES), .LANE_W(LANE_W)) u_mux (
            .src_flat (src_word),
            .sel      (ctrl.sel[g]),
            .lane_out (picked[g])
        );
        shuf_bit_flip #(.LANE_W(LANE_W)) u_flip (
            .din  (picked[g]),
            .en   (ctrl.mirror),
            .dout (shaped[g])
        );
    end

    shuf_legal_check #(.OPC_W_P(OPC_W)) u_legal (
        .opcode (sec_opcode),
        .level  (feat_level_e'(feat_level)),
        .legal  (legal)
    );

    always_comb begin
        next_res.valid   = in_valid && legal;
        next_res.illegal = in_valid && !legal;
        next_res.data    = next_res.valid ? shaped : '0;
    end

    if (REGISTERED) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) cur_res <= '0;
            else     cur_res <= next_res;
        end

        assert_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
            !(out_valid && out_illegal));
        assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
            (out_valid || out_illegal) |-> $past(in_valid));
        assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> (!out_valid && !out_illegal && out_word == '0));
        assert_identity_R9: assert property (@(posedge clk) disable iff (rst)
            (in_valid && legal && ctrl_imm == 9'h0E4) |=> (out_valid && out_word == $past(src_word)));
        assert_reset_R8: assert property (@(posedge clk)
            rst |=> (!out_valid && !out_illegal && out_word == '0));
    end else begin : g_comb
        assign cur_res = next_res;
    end

    assign out_valid   = cur_res.valid;
    assign out_illegal = cur_res.illegal;
    assign out_word    = cur_res.data;
endmodule

// File: tb/sim_byte_permute_unit.sv
module sim_byte_permute_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] src_word;
    logic [8:0]  ctrl_imm;
    logic [6:0]  sec_opcode;
    logic [1:0]  feat_level;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_illegal;

    always #5 clk = ~clk;

    byte_permute_unit #(.REGISTERED(1'b1)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_word(src_word),
        .ctrl_imm(ctrl_imm), .sec_opcode(sec_opcode), .feat_level(feat_level),
        .out_valid(out_valid), .out_word(out_word), .out_illegal(out_illegal)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    logic        exp_v, exp_i;
    logic [31:0] exp_w;
    string       exp_tag;
    bit          have_exp = 0;

    function automatic logic [31:0] model(input logic [31:0] s, input logic [8:0] c);
        logic [31:0] r = 0;
        for (int d = 0; d < 4; d++) begin
            int k = (c >> (2*d)) & 3;
            int bv = (s >> (8*k)) & 8'hFF;
            int ov = bv;
            if (c[8]) begin
                ov = 0;
                for (int b = 0; b < 8; b++) if ((bv >> b) & 1) ov |= 1 << (7-b);
            end
            r |= 32'(ov) << (8*d);
        end
        return r;
    endfunction

    task automatic compare();
        vectors++;
        if (out_valid !== exp_v || out_illegal !== exp_i || out_word !== exp_w) begin
            miscompares++;
            $display("FAIL %s: actual v=%0b i=%0b w=%h expected v=%0b i=%0b w=%h",
                     exp_tag, out_valid, out_illegal, out_word, exp_v, exp_i, exp_w);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] s, input logic [8:0] c,
                        input logic [6:0] op, input logic [1:0] lvl, input string tag);
        @(negedge clk);
        if (have_exp) compare();
        in_valid = v; src_word = s; ctrl_imm = c; sec_opcode = op; feat_level = lvl;
        exp_v = v && op == 7'h07 && lvl == 2'd3;
        exp_i = v && !(op == 7'h07 && lvl == 2'd3);
        exp_w = exp_v ? model(s, c) : 32'h0;
        exp_tag = tag;
        have_exp = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst = 1; in_valid = 0; src_word = 0; ctrl_imm = 0; sec_opcode = 0; feat_level = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        exp_v = 0; exp_i = 0; exp_w = 0; exp_tag = "R8 reset";
        compare();
        rst = 0;
        exp_tag = "R7 idle after reset";
        have_exp = 1;
        // identity and in-place mirror
        step(1, 32'h89ABCDEF, 9'h0E4, 7'h07, 2'd3, "R9 identity");
        step(1, 32'h89ABCDEF, 9'h1E4, 7'h07, 2'd3, "R9 R4 mirror in place");
        // lane 0 selector
        for (int k = 0; k < 4; k++)
            step(1, 32'h44332211, 9'(k), 7'h07, 2'd3, "R1 lane0 select");
        // upper lanes
        step(1, 32'hDEADBEEF, 9'h01B, 7'h07, 2'd3, "R2 byte reverse");
        step(1, 32'hDEADBEEF, 9'h04E, 7'h07, 2'd3, "R2 half swap");
        step(1, 32'hDEADBEEF, 9'h0B1, 7'h07, 2'd3, "R2 pair swap");
        // replication
        step(1, 32'hA1B2C3D4, 9'h000, 7'h07, 2'd3, "R3 replicate lane0");
        step(1, 32'hA1B2C3D4, 9'h0FF, 7'h07, 2'd3, "R3 replicate lane3");
        step(1, 32'hA1B2C3D4, 9'h155, 7'h07, 2'd3, "R3 R4 replicate mirrored");
        step(1, 32'h80010F7E, 9'h1E4, 7'h07, 2'd3, "R4 mirror edge bits");
        // illegal cases
        for (int l = 0; l < 3; l++)
            step(1, 32'h12345678, 9'h0E4, 7'h07, 2'(l), "R5 low level");
        step(1, 32'h12345678, 9'h0E4, 7'h06, 2'd3, "R5 wrong opcode");
        step(1, 32'h12345678, 9'h0E4, 7'h47, 2'd3, "R5 wrong opcode high bit");
        // idle with busy inputs
        step(0, 32'hFFFFFFFF, 9'h1FF, 7'h07, 2'd3, "R7 idle");
        step(0, 32'h12345678, 9'h0E4, 7'h00, 2'd0, "R7 idle");
        // back-to-back random traffic
        for (int n = 0; n < 400; n++) begin
            logic [1:0] lv = ($urandom % 5 == 0) ? 2'($urandom) : 2'd3;
            logic [6:0] op = ($urandom % 7 == 0) ? 7'($urandom) : 7'h07;
            step(1'($urandom % 8 != 0), $urandom, 9'($urandom), op, lv, "R6 R2 random");
        end
        step(0, 0, 0, 0, 0, "R7 final idle");
        @(negedge clk);
        compare();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule